// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

This block turns a pointing-device event into a five-byte serial mouse packet and queues those bytes in a receive FIFO. A host reads the FIFO one byte at a time through a data port. An event is a one-cycle strobe that carries signed X and Y deltas and the state of three buttons. A small sequencer expands each accepted event into its five bytes and pushes one byte per clock into the FIFO.

The first byte is the header. It has a fixed high pattern, and its three low bits are active-low button flags. The X byte carries the X delta and the Y byte carries the negated Y delta. Both deltas are clamped to the symmetric range of -127 to +127 and written as two's complement. Two zero bytes close every packet. The FIFO reports an occupancy count and a data-available flag.

A reader issues a one-cycle read strobe and takes the byte from the read-data port on the following cycle. A synchronous clear empties the FIFO and abandons any packet that is being built. The delta width is a parameter and must be at least 8 bits.

Top module: `mouse_pkt_enc`

## Requirements
- R1: Each accepted event pushes five bytes in this order: header, X byte, Y byte, 0x00, 0x00. The bytes are pushed one per clock, and the header enters the FIFO on the clock edge after the edge that accepted the strobe.
- R2: The header starts from 0x87. A pressed left button clears bit 2, a pressed middle button clears bit 1 and a pressed right button clears bit 0. Bits 7..3 are always 10000.
- R3: The X byte is the X delta clamped to -127..+127, in 8-bit two's complement. Values above +127 give 0x7F and values below -127 give 0x81.
- R4: The Y byte is the negated Y delta, clamped to -127..+127 in the same way. For example, -128 gives 0x7F and +127 gives 0x81.
- R5: The FIFO holds FIFO_DEPTH bytes (256 by default). A push into a full FIFO is dropped, and the count stays at FIFO_DEPTH.
- R6: A read strobe on a non-empty FIFO returns the oldest byte on rd_data_o in the next cycle, and it lowers count_o by one.
- R7: A read strobe on an empty FIFO returns 0x00 in the next cycle and leaves count_o at zero.
- R8: avail_o is set by every accepted push. It stays high after a read that leaves bytes behind, and it is low once the last byte is read. It is therefore high exactly when count_o is non-zero.
- R9: A strobe that arrives while a packet is in progress goes into a single pending slot. A later strobe in the same packet overwrites that slot. The pending event starts one idle cycle after the current packet ends.
- R10: clear_i empties the FIFO, ends the current packet, discards the pending event and drops any strobe in the same cycle. Afterwards count_o is 0 and avail_o is low.
- R11: After reset, count_o is 0, avail_o is low and rd_data_o is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of FIFO and sequencer |
| evt_valid_i | input | 1 | One-cycle event strobe |
| dx_i | input | DELTA_W | Signed X delta |
| dy_i | input | DELTA_W | Signed Y delta |
| btn_left_i | input | 1 | Left button pressed |
| btn_mid_i | input | 1 | Middle button pressed |
| btn_right_i | input | 1 | Right button pressed |
| rd_i | input | 1 | Read strobe |
| rd_data_o | output | 8 | Byte returned by the previous read |
| avail_o | output | 1 | FIFO holds at least one byte |
| count_o | output | $clog2(FIFO_DEPTH+1) | FIFO occupancy |

## Verification
The bench drives deltas at the clamp limits: ±127, ±128, a value far out of range, and the most negative input. A design that clamps asymmetrically would emit 0x80, and one that forgets to negate Y would give the wrong sign.

The bench sends 52 events so that the FIFO overflows partway through a packet. A design that wraps its write pointer over unread data, or that lets the count pass the depth, would then return the wrong bytes when the FIFO is drained.

The bench sends three strobes inside one packet. A design that queues every strobe, or that keeps the first pending one instead of the last, would produce an extra or wrong packet.

The bench also reads an empty FIFO and clears the block in the middle of a packet. A design that underflows the count, or that keeps pushing after the clear, would leave count_o non-zero.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
  localparam int unsigned PKT_BYTES = 5;
  localparam logic [7:0]  HDR_BASE  = 8'h87;

  typedef enum logic [2:0] {
    SLOT_HDR  = 3'd0,
    SLOT_DX   = 3'd1,
    SLOT_DY   = 3'd2,
    SLOT_PAD0 = 3'd3,
    SLOT_PAD1 = 3'd4
  } slot_e;

  typedef struct packed {
    logic [7:0] hdr;
    logic [7:0] dx;
    logic [7:0] dy;
  } pkt_t;
endpackage

// File: rtl/mpe_sat.sv
// Clamp a signed delta to -127..+127, optionally negated first.
module mpe_sat #(
  parameter int unsigned IN_W = 10,
  parameter bit          NEG  = 1'b0
) (
  input  logic signed [IN_W-1:0] d_i,
  output logic        [7:0]      q_o
);
  localparam int unsigned EW = IN_W + 1;
  localparam logic signed [EW-1:0] POS_LIM = EW'(127);
  localparam logic signed [EW-1:0] NEG_LIM = EW'(-127);

  logic signed [EW-1:0] ext;
  logic signed [EW-1:0] val;

  assign ext = {d_i[IN_W-1], d_i};

  generate
    if (NEG) begin : g_neg
      assign val = -ext;
    end else begin : g_pos
      assign val = ext;
    end
  endgenerate

  always_comb begin
    if (val > POS_LIM)      q_o = 8'h7F;
    else if (val < NEG_LIM) q_o = 8'h81;
    else                    q_o = val[7:0];
  end
endmodule

// File: rtl/mpe_seq.sv
// Expands one event into five pushes, with a single pending slot.
module mpe_seq
  import mpe_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       evt_valid_i,
  input  pkt_t       evt_pkt_i,
  output logic       push_o,
  output logic [7:0] push_data_o,
  output slot_e      slot_o
);
  logic  busy_q;
  slot_e slot_q;
  pkt_t  cur_q;
  logic  pend_v_q;
  pkt_t  pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      slot_q   <= SLOT_HDR;
      cur_q    <= '0;
      pend_v_q <= 1'b0;
      pend_q   <= '0;
    end else if (clear_i) begin
      busy_q   <= 1'b0;
      slot_q   <= SLOT_HDR;
      pend_v_q <= 1'b0;
    end else if (busy_q) begin
      if (slot_q == SLOT_PAD1) busy_q <= 1'b0;
      else                     slot_q <= slot_e'(slot_q + 3'd1);
      if (evt_valid_i) begin
        pend_v_q <= 1'b1;
        pend_q   <= evt_pkt_i;
      end
    end else if (pend_v_q) begin
      busy_q   <= 1'b1;
      slot_q   <= SLOT_HDR;
      cur_q    <= pend_q;
      pend_v_q <= evt_valid_i;
      if (evt_valid_i) pend_q <= evt_pkt_i;
    end else if (evt_valid_i) begin
      busy_q <= 1'b1;
      slot_q <= SLOT_HDR;
      cur_q  <= evt_pkt_i;
    end
  end

  always_comb begin
    unique case (slot_q)
      SLOT_HDR: push_data_o = cur_q.hdr;
      SLOT_DX:  push_data_o = cur_q.dx;
      SLOT_DY:  push_data_o = cur_q.dy;
      default:  push_data_o = 8'h00;
    endcase
  end

  assign push_o = busy_q;
  assign slot_o = slot_q;
endmodule

// File: rtl/mpe_fifo.sv
// Byte FIFO: drop on full, zero on empty read, registered read data.
module mpe_fifo #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned W     = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          push_i,
  input  logic [W-1:0]  push_data_i,
  input  logic          pop_i,
  output logic [W-1:0]  pop_data_o,
  output logic [CW-1:0] count_o,
  output logic          avail_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q;
  logic          avail_q;
  logic [W-1:0]  rd_q;
  logic          do_push, do_pop;

  assign do_push = push_i && (count_q < CW'(DEPTH));
  assign do_pop  = pop_i && (count_q != '0);

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push && !clear_i) mem[wptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
      avail_q <= 1'b0;
      rd_q    <= '0;
    end else if (clear_i) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
      avail_q <= 1'b0;
      rd_q    <= '0;
    end else begin
      if (do_push) wptr_q <= ptr_inc(wptr_q);
      if (do_pop)  rptr_q <= ptr_inc(rptr_q);
      if (pop_i)   rd_q   <= do_pop ? mem[rptr_q] : '0;
      unique case ({do_push, do_pop})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
      if (do_push)     avail_q <= 1'b1;
      else if (do_pop) avail_q <= (count_q > CW'(1));
    end
  end

  assign pop_data_o = rd_q;
  assign count_o    = count_q;
  assign avail_o    = avail_q;
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc
  import mpe_pkg::*;
#(
  parameter int unsigned DELTA_W    = 10,
  parameter int unsigned FIFO_DEPTH = 256,
  localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     evt_valid_i,
  input  logic signed [DELTA_W-1:0] dx_i,
  input  logic signed [DELTA_W-1:0] dy_i,
  input  logic                     btn_left_i,
  input  logic                     btn_mid_i,
  input  logic                     btn_right_i,
  input  logic                     rd_i,
  output logic [7:0]               rd_data_o,
  output logic                     avail_o,
  output logic [CNT_W-1:0]         count_o
);
  pkt_t       evt_pkt;
  logic       seq_push;
  logic [7:0] seq_byte;
  slot_e      seq_slot;

  // Buttons are active-low in the header.
  assign evt_pkt.hdr = HDR_BASE ^ {5'b0, btn_left_i, btn_mid_i, btn_right_i};

  mpe_sat #(.IN_W(DELTA_W), .NEG(1'b0)) i_sat_x (.d_i(dx_i), .q_o(evt_pkt.dx));
  mpe_sat #(.IN_W(DELTA_W), .NEG(1'b1)) i_sat_y (.d_i(dy_i), .q_o(evt_pkt.dy));

  mpe_seq i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_i),
    .evt_valid_i (evt_valid_i),
    .evt_pkt_i   (evt_pkt),
    .push_o      (seq_push),
    .push_data_o (seq_byte),
    .slot_o      (seq_slot)
  );

  mpe_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) i_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_i),
    .push_i      (seq_push),
    .push_data_i (seq_byte),
    .pop_i       (rd_i),
    .pop_data_o  (rd_data_o),
    .count_o     (count_o),
    .avail_o     (avail_o)
  );
endmodule

// File: rtl/mouse_pkt_enc_chk.sv
module mouse_pkt_enc_chk #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned CW    = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clear_i,
  input logic          rd_i,
  input logic [7:0]    rd_data_o,
  input logic          avail_o,
  input logic [CW-1:0] count_o,
  input logic          seq_push,
  input logic [2:0]    seq_slot,
  input logic [7:0]    seq_byte
);
  p_slot_order_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_push && seq_slot != 3'd4 && !clear_i) |=> (seq_push && seq_slot == $past(seq_slot) + 3'd1));

  p_pad_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_push && seq_slot >= 3'd3) |-> seq_byte == 8'h00);

  p_hdr_form_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_push && seq_slot == 3'd0) |-> seq_byte[7:3] == 5'b10000);

  p_x_clamp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_push && seq_slot == 3'd1) |-> seq_byte != 8'h80);

  p_y_clamp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_push && seq_slot == 3'd2) |-> seq_byte != 8'h80);

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));

  p_full_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == CW'(DEPTH) && !rd_i && !clear_i) |=> count_o == CW'(DEPTH));

  p_count_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (count_o == $past(count_o) || count_o == $past(count_o) + CW'(1)
                  || count_o + CW'(1) == $past(count_o)));

  p_empty_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && count_o == '0 && !clear_i) |=> (rd_data_o == 8'h00 && count_o <= CW'(1)));

  p_avail_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avail_o == (count_o != '0));

  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (count_o == '0 && !avail_o && !seq_push));
endmodule

bind mouse_pkt_enc mouse_pkt_enc_chk #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clear_i   (clear_i),
  .rd_i      (rd_i),
  .rd_data_o (rd_data_o),
  .avail_o   (avail_o),
  .count_o   (count_o),
  .seq_push  (seq_push),
  .seq_slot  (seq_slot),
  .seq_byte  (seq_byte)
);

// File: tb/test_mouse_pkt_enc.sv
`timescale 1ns/1ps
module test_mouse_pkt_enc;
  localparam int DW    = 10;
  localparam int DEPTH = 256;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic clear_i = 1'b0;
  logic evt_valid_i = 1'b0;
  logic signed [DW-1:0] dx_i = '0;
  logic signed [DW-1:0] dy_i = '0;
  logic btn_left_i = 1'b0, btn_mid_i = 1'b0, btn_right_i = 1'b0;
  logic rd_i = 1'b0;
  logic [7:0] rd_data_o;
  logic avail_o;
  logic [CW-1:0] count_o;

  always #10 clk = ~clk;

  mouse_pkt_enc #(.DELTA_W(DW), .FIFO_DEPTH(DEPTH)) i_mouse_pkt_enc (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear_i), .evt_valid_i(evt_valid_i),
    .dx_i(dx_i), .dy_i(dy_i), .btn_left_i(btn_left_i), .btn_mid_i(btn_mid_i),
    .btn_right_i(btn_right_i), .rd_i(rd_i), .rd_data_o(rd_data_o),
    .avail_o(avail_o), .count_o(count_o));

  int n_checks = 0;
  int n_fail   = 0;
  string cur_tag = "R6";
  logic [7:0] exp_q[$];
  logic rd_seen = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  function automatic logic [7:0] clamp8(input int v);
    if (v > 127)  return 8'h7F;
    if (v < -127) return 8'h81;
    return v[7:0];
  endfunction

  function automatic logic [7:0] hdr(input bit l, input bit m, input bit r);
    return 8'h87 ^ {5'b0, l, m, r};
  endfunction

  task automatic push_exp(input logic [7:0] b);
    if (exp_q.size() < DEPTH) exp_q.push_back(b);
  endtask

  task automatic model_evt(input int dx, input int dy, input bit l, input bit m, input bit r);
    push_exp(hdr(l, m, r));
    push_exp(clamp8(dx));
    push_exp(clamp8(-dy));
    push_exp(8'h00);
    push_exp(8'h00);
  endtask

  task automatic drive_evt(input int dx, input int dy, input bit l, input bit m, input bit r);
    evt_valid_i = 1'b1;
    dx_i = DW'(dx);
    dy_i = DW'(dy);
    btn_left_i = l; btn_mid_i = m; btn_right_i = r;
    @(negedge clk);
    evt_valid_i = 1'b0;
  endtask

  // Driver: model then stimulus, then let the packet drain into the FIFO.
  task automatic send_evt(input int dx, input int dy, input bit l, input bit m, input bit r);
    model_evt(dx, dy, l, m, r);
    drive_evt(dx, dy, l, m, r);
    repeat (6) @(negedge clk);
  endtask

  task automatic read_byte();
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  task automatic drain(input string tag);
    cur_tag = tag;
    while (count_o != '0) read_byte();
    @(negedge clk);
  endtask

  // Monitor: compares each read result against the scoreboard.
  always @(posedge clk) rd_seen <= rst_ni && rd_i && !clear_i;
  always @(negedge clk) begin
    if (rd_seen) begin
      logic [7:0] e;
      e = (exp_q.size() != 0) ? exp_q.pop_front() : 8'h00;
      check(rd_data_o == e, cur_tag, int'(rd_data_o), int'(e));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(count_o == '0, "R11", int'(count_o), 0);
    check(avail_o == 1'b0, "R11", int'(avail_o), 0);
    check(rd_data_o == 8'h00, "R11", int'(rd_data_o), 0);

    // R1 basic packet
    send_evt(5, 3, 0, 0, 0);
    check(count_o == CW'(5), "R1", int'(count_o), 5);
    check(avail_o == 1'b1, "R8", int'(avail_o), 1);
    drain("R1");
    check(avail_o == 1'b0, "R8", int'(avail_o), 0);

    // R2 buttons
    send_evt(0, 0, 1, 0, 0);
    send_evt(0, 0, 0, 1, 0);
    send_evt(0, 0, 0, 0, 1);
    send_evt(0, 0, 1, 1, 1);
    drain("R2");

    // R3 X clamp
    send_evt(300, 0, 0, 0, 0);
    send_evt(-300, 0, 0, 0, 0);
    send_evt(-128, 0, 0, 0, 0);
    send_evt(127, 0, 0, 0, 0);
    send_evt(-127, 0, 0, 0, 0);
    send_evt(-512, 0, 0, 0, 0);
    drain("R3");

    // R4 Y negate and clamp
    send_evt(0, 300, 0, 0, 0);
    send_evt(0, -300, 0, 0, 0);
    send_evt(0, -128, 0, 0, 0);
    send_evt(0, 127, 0, 0, 0);
    send_evt(0, -127, 0, 0, 0);
    send_evt(0, -512, 0, 0, 0);
    drain("R4");

    // R6 partial read
    send_evt(-9, 40, 1, 0, 1);
    cur_tag = "R6";
    read_byte();
    read_byte();
    @(negedge clk);
    check(count_o == CW'(3), "R6", int'(count_o), 3);
    check(avail_o == 1'b1, "R8", int'(avail_o), 1);
    drain("R6");

    // R7 empty read
    cur_tag = "R7";
    read_byte();
    @(negedge clk);
    check(count_o == '0, "R7", int'(count_o), 0);

    // R5 overflow: 52 packets into a 256-byte FIFO
    for (int i = 0; i < 52; i++) send_evt(i - 26, 26 - i, i[0], i[1], i[2]);
    check(count_o == CW'(DEPTH), "R5", int'(count_o), DEPTH);
    send_evt(1, 1, 0, 0, 0);
    check(count_o == CW'(DEPTH), "R5", int'(count_o), DEPTH);
    check(avail_o == 1'b1, "R8", int'(avail_o), 1);
    drain("R5");

    // R9 pending slot: A, then B overwritten by C
    model_evt(10, 10, 0, 0, 0);
    model_evt(-30, -30, 0, 0, 1);
    drive_evt(10, 10, 0, 0, 0);
    drive_evt(20, 20, 1, 0, 0);
    drive_evt(-30, -30, 0, 0, 1);
    repeat (15) @(negedge clk);
    check(count_o == CW'(10), "R9", int'(count_o), 10);
    drain("R9");

    // R10 clear mid-packet with a pending event
    drive_evt(50, 50, 0, 0, 0);
    drive_evt(60, 60, 0, 0, 0);
    clear_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0;
    exp_q.delete();
    repeat (12) @(negedge clk);
    check(count_o == '0, "R10", int'(count_o), 0);
    check(avail_o == 1'b0, "R10", int'(avail_o), 0);

    // R10 strobe in the clear cycle is dropped
    clear_i = 1'b1;
    drive_evt(7, 7, 0, 0, 0);
    clear_i = 1'b0;
    repeat (8) @(negedge clk);
    check(count_o == '0, "R10", int'(count_o), 0);
    cur_tag = "R10";
    read_byte();
    @(negedge clk);

    report();
  end
endmodule